// File: doc/BRIEF.md
# Selectable-Rounding Word-Width Reducer

This block shortens a signed two's-complement sample by dropping a parameterised number of low-order fraction bits. The narrower result goes out one clock later. A two-bit mode input picks the rounding rule for each sample:

- plain floor truncation;
- round-half-up;
- round-half-away-from-zero;
- round-half-to-even.

Each rule settles exact half-LSB ties its own way. Round-half-to-even is the one to use in a DSP datapath where midpoint values must not leave a steady DC offset.

When rounding pushes the value past the output range, the result clips to the nearest representable limit and an overflow flag is raised with that sample. In the default configuration a 31-bit word loses 15 bits and gives a 16-bit word. The same block also works when only one bit is dropped. In that case every odd input is a tie, so the tie rule decides the result for half of all inputs.

Top module: `requant_round`

## Requirements
- R1: While `rst_n` is low and in the first output cycle after reset, `out_valid`, `out_ovf` and `out_data` are all zero.
- R2: `out_valid` equals `in_valid` of the previous clock cycle. After a cycle with `in_valid` low, `out_data` keeps its previous value and `out_ovf` is low.
- R3: With `mode` = 2'b00 (truncate), the result is floor(x / 2^DROP). For example, -17.1 gives -18 and 17.99 gives 17.
- R4: With `mode` = 2'b01 (half-up), the result is floor(x / 2^DROP + 0.5). For example, 2.5 gives 3 and -2.5 gives -2.
- R5: With `mode` = 2'b10 (half-away), non-tie values go to the nearest integer and exact ties move away from zero. For example, 12.5 gives 13 and -12.5 gives -13.
- R6: With `mode` = 2'b11 (half-even), non-tie values go to the nearest integer and exact ties go to the even neighbour. For example, 12.5 gives 12, -12.5 gives -12 and 13.5 gives 14.
- R7: A rounded value above 2^(OUT_W-1)-1 gives exactly that maximum with `out_ovf` high in the same output cycle. A value below -2^(OUT_W-1) gives that minimum with `out_ovf` high. Any in-range value gives `out_ovf` low.
- R8: With DROP = 1, each of the four modes rounds odd inputs (exact ties) by its own tie rule as stated in R3 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed wide sample, DROP fraction bits |
| mode | input | 2 | Rounding rule: 00 truncate, 01 half-up, 10 half-away, 11 half-even |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_data | output | OUT_W | Signed rounded and clipped result |
| out_ovf | output | 1 | Result was clipped to a range limit |

## Verification
The rounding increment and the output clipping can act on the same sample. This happens when the kept part already equals the largest positive code and the dropped fraction calls for a step up. The bench provokes it by feeding that top code with an exact half fraction in every mode. It also feeds the same top code with a fraction above one half. The bench then judges, per mode, whether the result stays at the top code with the flag low (truncate, and half-even only if the kept LSB were even) or is clipped with the flag high. Randomly drawn ties near both range ends repeat this check across all four rules.

// File: rtl/requant_pkg.sv
package requant_pkg;

   typedef enum logic [1:0] {
      RQ_TRUNC     = 2'b00,
      RQ_HALF_UP   = 2'b01,
      RQ_HALF_AWAY = 2'b10,
      RQ_HALF_EVEN = 2'b11
   } rq_mode_e;

endpackage

// File: rtl/requant_round_decide.sv
// Decides whether the kept part must be stepped up by one LSB.
module requant_round_decide
   import requant_pkg::*;
#(
   parameter int DROP = 15
) (
   input  rq_mode_e          mode,
   input  logic              sign_bit,
   input  logic              keep_lsb,
   input  logic [DROP-1:0]   frac,
   output logic              inc
);

   logic half_bit;
   logic below_nz;

   assign half_bit = frac[DROP-1];

   generate
      if (DROP == 1) begin : g_single
         assign below_nz = 1'b0;
      end else begin : g_multi
         assign below_nz = |frac[DROP-2:0];
      end
   endgenerate

   always_comb begin
      unique case (mode)
         RQ_TRUNC:     inc = 1'b0;
         RQ_HALF_UP:   inc = half_bit;
         RQ_HALF_AWAY: inc = half_bit & (below_nz | ~sign_bit);
         RQ_HALF_EVEN: inc = half_bit & (below_nz | keep_lsb);
         default:      inc = 1'b0;
      endcase
   end

endmodule

// File: rtl/requant_sat.sv
// Clips a signed sum to OUT_W bits and reports clipping.
module requant_sat #(
   parameter int SUM_W = 17,
   parameter int OUT_W = 16
) (
   input  logic [SUM_W-1:0] sum,
   output logic [OUT_W-1:0] res,
   output logic             clip
);

   localparam int HI_W = SUM_W - OUT_W + 1;

   logic [HI_W-1:0] hi;
   logic            fits;

   assign hi   = sum[SUM_W-1:OUT_W-1];
   assign fits = (hi == '0) || (hi == '1);

   always_comb begin
      if (fits) begin
         res  = sum[OUT_W-1:0];
         clip = 1'b0;
      end else if (sum[SUM_W-1]) begin
         res  = {1'b1, {(OUT_W-1){1'b0}}};
         clip = 1'b1;
      end else begin
         res  = {1'b0, {(OUT_W-1){1'b1}}};
         clip = 1'b1;
      end
   end

endmodule

// File: rtl/requant_round.sv
module requant_round
   import requant_pkg::*;
#(
   parameter int IN_W  = 31,
   parameter int DROP  = 15,
   parameter int OUT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   input  logic [1:0]        mode,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_ovf
);

   localparam int KEEP  = IN_W - DROP;
   localparam int SUM_W = KEEP + 1;

   generate
      if (DROP < 1 || DROP >= IN_W) begin : g_bad_drop
         $error("requant_round: DROP must lie in 1..IN_W-1");
      end
      if (OUT_W < 2 || OUT_W > KEEP) begin : g_bad_out
         $error("requant_round: OUT_W must lie in 2..IN_W-DROP");
      end
   endgenerate

   logic [KEEP-1:0]  kept;
   logic [DROP-1:0]  frac;
   logic             inc;
   logic [SUM_W-1:0] sum;
   logic [OUT_W-1:0] res;
   logic             clip;

   assign kept = in_data[IN_W-1:DROP];
   assign frac = in_data[DROP-1:0];

   requant_round_decide #(.DROP(DROP)) u_decide (
      .mode     (rq_mode_e'(mode)),
      .sign_bit (in_data[IN_W-1]),
      .keep_lsb (kept[0]),
      .frac     (frac),
      .inc      (inc)
   );

   assign sum = {kept[KEEP-1], kept} + SUM_W'(inc);

   requant_sat #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_sat (
      .sum  (sum),
      .res  (res),
      .clip (clip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ovf   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_ovf   <= in_valid & clip;
         if (in_valid) out_data <= res;
      end
   end

endmodule

// File: rtl/requant_round_chk.sv
module requant_round_chk #(
   parameter int IN_W  = 31,
   parameter int DROP  = 15,
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       mode,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_data,
   input logic             out_ovf
);

   localparam int KEEP = IN_W - DROP;
   localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_R1: assert (!out_valid || $isunknown(out_valid))
            else $error("R1 out_valid high in reset");
      end
   end

   assert_valid_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_ovf && $stable(out_data)));

   assert_ovf_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> out_valid);

   assert_ovf_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> (out_data == MAXV || out_data == MINV));

   generate
      if (OUT_W == KEEP) begin : g_trunc_chk
         assert_trunc_no_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 2'b00) |=> !out_ovf);
      end
   endgenerate

endmodule

bind requant_round requant_round_chk #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/requant_round_bench.sv
module requant_round_bench;

   localparam int IN_W = 31, DROP = 15, OUT_W = 16;
   localparam int IN2_W = 17, DROP2 = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              in_valid = 1'b0;
   logic [IN_W-1:0]   in_data  = '0;
   logic [1:0]        mode     = 2'b00;
   logic              out_valid;
   logic [OUT_W-1:0]  out_data;
   logic              out_ovf;

   logic              in_valid2 = 1'b0;
   logic [IN2_W-1:0]  in_data2  = '0;
   logic              out_valid2;
   logic [OUT_W-1:0]  out_data2;
   logic              out_ovf2;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   requant_round #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W)) u_requant_round (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
      .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf));

   requant_round #(.IN_W(IN2_W), .DROP(DROP2), .OUT_W(OUT_W)) u_requant_round_d1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid2), .in_data(in_data2), .mode(mode),
      .out_valid(out_valid2), .out_data(out_data2), .out_ovf(out_ovf2));

   // Expected rounded value (before clipping) from the rule of each mode.
   function automatic longint ref_round(longint x, int drop, int md);
      longint k, f, h;
      k = x >>> drop;
      f = x - (k <<< drop);
      h = longint'(1) <<< (drop - 1);
      case (md)
         0: return k;
         1: return (f >= h) ? k + 1 : k;
         2: begin
            if (f > h) return k + 1;
            if (f == h) return (x >= 0) ? k + 1 : k;
            return k;
         end
         default: begin
            if (f > h) return k + 1;
            if (f == h) return k + (k & 1);
            return k;
         end
      endcase
   endfunction

   function automatic longint ref_clip(longint v);
      longint mx, mn;
      mx = (longint'(1) <<< (OUT_W - 1)) - 1;
      mn = -(longint'(1) <<< (OUT_W - 1));
      if (v > mx) return mx;
      if (v < mn) return mn;
      return v;
   endfunction

   function automatic string req_of(int md);
      case (md)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string req, longint got, longint exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, got, exp);
      end
   endtask

   // One sample through the wide instance; compare at the following negedge.
   task automatic run_wide(longint x, int md, string tag);
      longint r, e;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = IN_W'(x);
      mode     = 2'(md);
      @(negedge clk);
      in_valid = 1'b0;
      r = ref_round(x, DROP, md);
      e = ref_clip(r);
      check({tag, " data"}, longint'($signed(out_data)), e);
      check({"R7 ovf ", tag}, longint'(out_ovf), longint'(r != e));
      check("R2 valid", longint'(out_valid), 1);
   endtask

   task automatic run_narrow(longint x, int md);
      longint e;
      @(negedge clk);
      in_valid2 = 1'b1;
      in_data2  = IN2_W'(x);
      mode      = 2'(md);
      @(negedge clk);
      in_valid2 = 1'b0;
      e = ref_clip(ref_round(x, DROP2, md));
      check({"R8 ", req_of(md)}, longint'($signed(out_data2)), e);
   endtask

   function automatic longint fx(longint ip, longint fr);
      return (ip <<< DROP) + fr;
   endfunction

   initial begin
      longint hold_val;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 valid", longint'(out_valid), 0);
      check("R1 ovf", longint'(out_ovf), 0);
      check("R1 data", longint'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post-reset valid", longint'(out_valid), 0);

      // Directed ties and examples (half = 16384 with DROP 15).
      run_wide(fx(-18, 32768 - 3277), 0, "R3 -17.1");
      run_wide(fx(17, 32440), 0, "R3 17.99");
      run_wide(fx(2, 16384), 1, "R4 2.5");
      run_wide(fx(-3, 16384), 1, "R4 -2.5");
      run_wide(fx(12, 16384), 2, "R5 12.5");
      run_wide(fx(-13, 16384), 2, "R5 -12.5");
      run_wide(fx(-13, 16385), 2, "R5 -12.49");
      run_wide(fx(12, 16384), 3, "R6 12.5");
      run_wide(fx(-13, 16384), 3, "R6 -12.5");
      run_wide(fx(13, 16384), 3, "R6 13.5");
      run_wide(fx(12, 16385), 3, "R6 12.50003");
      // Increment and clipping in the same sample at the top code.
      for (int md = 0; md < 4; md++) begin
         run_wide(fx(32767, 16384), md, "R7 top tie");
         run_wide(fx(32767, 20000), md, "R7 top above");
      end
      run_wide(fx(-32768, 0), 1, "R7 bottom");
      run_wide(fx(-32768, 16384), 2, "R7 bottom tie");

      // Idle cycle: output held, no flag.
      hold_val = longint'($signed(out_data));
      @(negedge clk);
      in_data = IN_W'(fx(100, 0));
      mode    = 2'b01;
      @(negedge clk);
      check("R2 idle valid", longint'(out_valid), 0);
      check("R2 idle hold", longint'($signed(out_data)), hold_val);
      check("R2 idle ovf", longint'(out_ovf), 0);

      // Random stimulus, ties forced in a third of samples.
      for (int i = 0; i < 1500; i++) begin
         longint x;
         int md;
         x  = longint'($signed(IN_W'($urandom)));
         md = int'($urandom_range(0, 3));
         if ($urandom_range(0, 2) == 0)
            x = (x & ~((longint'(1) <<< DROP) - 1)) | (longint'(1) <<< (DROP - 1));
         run_wide(x, md, req_of(md));
      end

      // One-bit drop: odd inputs are ties.
      for (int md = 0; md < 4; md++) begin
         run_narrow(5, md);
         run_narrow(-5, md);
         run_narrow(7, md);
         run_narrow(65535, md);
      end
      for (int i = 0; i < 400; i++) begin
         run_narrow(longint'($signed(IN2_W'($urandom))), int'($urandom_range(0, 3)));
      end

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule